// File: doc/BRIEF.md
# Fixed-Point Subtract Unit with Condition Codes

This execution block subtracts a memory operand from general-register contents in two's-complement arithmetic. It handles three operand sizes. A halfword operand is sign-extended to a full word. A word operand is used as it stands. A doubleword operand is taken against an even/odd register pair that acts as one 64-bit register. The subtraction is done by adding the inverted operand and a carry-in of one to the register value. One 65-bit adder serves all three sizes. For the single-register forms, the word is placed in the upper half and the lower half is padded so that the carry ripples through unchanged.

Each accepted request returns, one clock later, the value to write back and per-register write enables. It also returns a four-bit condition code and, when needed, a trap request with a vector address. Bit numbering follows the big-endian convention: "bit 0" is the most significant bit. The condition code is exposed as `cc[3:0]`, where `cc[3]` is the carry flag, `cc[2]` is overflow, and `cc[1:0]` is the result class. The surrounding pipeline owns the register file, instruction fetch, address generation and the trap handler.

Top module: `fxsub_unit`

## Requirements
- R1: With `op`=00 (halfword), the result is R minus the sign-extended `operand[15:0]`. It appears on `res_hi` with `wr_hi`=1, `wr_lo`=0 and `res_lo`=0. `operand[63:16]` is ignored.
- R2: With `op`=01 (word), the result is R minus `operand[31:0]`. It appears on `res_hi` with `wr_hi`=1, `wr_lo`=0 and `res_lo`=0. `operand[63:32]` is ignored.
- R3: With `op`=10 (doubleword) and an even `reg_idx`, the 64-bit result of {`reg_hi`,`reg_lo`} minus `operand` is written. The upper 32 bits go to `res_hi` and the lower 32 bits to `res_lo`, with both `wr_hi` and `wr_lo` set.
- R4: `cc[3]` is 1 exactly when the subtraction produces a carry out of the most significant bit, which means no unsigned borrow (register value >= operand).
- R5: `cc[2]` is 1 exactly when the signed result does not fit the operation's width (32 bits, or 64 bits for doubleword).
- R6: `cc[1:0]` classifies the full result: 00 for zero, 01 for positive, 10 for negative. The value 11 never occurs.
- R7: When overflow occurs and `trap_mask`=1, `trap_req`=1 with `trap_vec`=8'h43, in the same cycle as the write enables. With `trap_mask`=0, no trap is raised.
- R8: A doubleword with an odd `reg_idx` raises `trap_req` with `trap_vec`=8'h4D. No write enable is set, and `cc`, `res_hi` and `res_lo` keep their previous values.
- R9: Each cycle with `in_valid`=1 yields `out_valid`=1 on the next cycle. A cycle without `in_valid` yields no `out_valid`, no write, no trap, and unchanged `cc` and results.
- R10: A synchronous reset clears every output to zero.
- R11: `op`=11 is reserved. It yields `out_valid` with no write, no trap, and `cc` and results unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Request strobe |
| op | input | 2 | 00 halfword, 01 word, 10 doubleword, 11 reserved |
| reg_idx | input | 4 | Register field R |
| reg_hi | input | 32 | Contents of R |
| reg_lo | input | 32 | Contents of R+1 (doubleword only) |
| operand | input | 64 | Effective operand, right-justified |
| trap_mask | input | 1 | Arithmetic trap enable |
| out_valid | output | 1 | Result strobe, one cycle after the request |
| res_hi | output | 32 | Value for R |
| res_lo | output | 32 | Value for R+1 |
| wr_hi | output | 1 | Write enable for R |
| wr_lo | output | 1 | Write enable for R+1 |
| cc | output | 4 | {carry, overflow, class[1:0]} |
| trap_req | output | 1 | Trap request |
| trap_vec | output | 8 | Trap vector address |

## Verification
The bench aims at the signed edges: subtracting the most negative word or doubleword from zero, subtracting a negative halfword from the largest positive word, and a halfword of 16'h8000. A design that took overflow from the uncomplemented operand, or sign-extended the wrong bit, would flag or miss these cases. Equal operands check that zero classifies as 00 and that the carry reads 1 with no borrow. An inverted carry sense would show up here. Odd-pair doubleword requests and reserved opcodes are placed between ordinary ones, so a design that leaked a write or refreshed the condition code on them would diverge from the scoreboard on the next comparison. A long run of back-to-back requests with random masks tests that traps follow only masked overflow.

// File: rtl/fxsub_unit.sv
module fxsub_unit #(
  parameter int W  = 32,
  parameter int HW = 16,
  parameter int RW = 4,
  parameter int VW = 8,
  parameter logic [VW-1:0] OVF_VEC = 8'h43,
  parameter logic [VW-1:0] ODD_VEC = 8'h4D
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            in_valid,
  input  logic [1:0]      op,
  input  logic [RW-1:0]   reg_idx,
  input  logic [W-1:0]    reg_hi,
  input  logic [W-1:0]    reg_lo,
  input  logic [2*W-1:0]  operand,
  input  logic            trap_mask,
  output logic            out_valid,
  output logic [W-1:0]    res_hi,
  output logic [W-1:0]    res_lo,
  output logic            wr_hi,
  output logic            wr_lo,
  output logic [3:0]      cc,
  output logic            trap_req,
  output logic [VW-1:0]   trap_vec
);

  localparam int DW = 2 * W;
  localparam logic [1:0] OP_HALF = 2'b00;
  localparam logic [1:0] OP_WORD = 2'b01;
  localparam logic [1:0] OP_DBL  = 2'b10;

  wire is_half  = (op == OP_HALF);
  wire is_word  = (op == OP_WORD);
  wire is_dbl   = (op == OP_DBL);
  wire odd_pair = is_dbl & reg_idx[0];
  wire is_arith = is_half | is_word | is_dbl;

  // single-register forms sit in the upper half; the all-ones low half plus
  // carry-in of one passes a clean carry into the upper half
  wire [W-1:0]  sub_w = is_half ? {{(W-HW){operand[HW-1]}}, operand[HW-1:0]}
                                : operand[W-1:0];
  wire [DW-1:0] a_v   = is_dbl ? {reg_hi, reg_lo} : {reg_hi, {W{1'b0}}};
  wire [DW-1:0] b_n   = is_dbl ? ~operand : {~sub_w, {W{1'b1}}};
  wire [DW:0]   sum   = {1'b0, a_v} + {1'b0, b_n} + (DW+1)'(1);

  wire carry = sum[DW];
  wire ovf   = (a_v[DW-1] == b_n[DW-1]) && (sum[DW-1] != a_v[DW-1]);
  wire neg   = sum[DW-1];
  wire zero  = (sum[DW-1:0] == '0);
  wire [1:0] cls = neg ? 2'b10 : (zero ? 2'b00 : 2'b01);

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      res_hi    <= '0;
      res_lo    <= '0;
      wr_hi     <= 1'b0;
      wr_lo     <= 1'b0;
      cc        <= '0;
      trap_req  <= 1'b0;
      trap_vec  <= '0;
    end else begin
      out_valid <= in_valid;
      wr_hi     <= 1'b0;
      wr_lo     <= 1'b0;
      trap_req  <= 1'b0;
      trap_vec  <= '0;
      if (in_valid) begin
        if (odd_pair) begin
          trap_req <= 1'b1;
          trap_vec <= ODD_VEC;
        end else if (is_arith) begin
          res_hi <= sum[DW-1 -: W];
          res_lo <= is_dbl ? sum[W-1:0] : '0;
          wr_hi  <= 1'b1;
          wr_lo  <= is_dbl;
          cc     <= {carry, ovf, cls};
          if (ovf && trap_mask) begin
            trap_req <= 1'b1;
            trap_vec <= OVF_VEC;
          end
        end
      end
    end
  end

  // R6: class field never reads 11
  a_r6_cls_legal: assert property (@(posedge clk) disable iff (rst)
    cc[1:0] != 2'b11);

  // R3: R+1 is only written together with R
  a_r3_pair_write: assert property (@(posedge clk) disable iff (rst)
    wr_lo |-> wr_hi);

  // R7: overflow trap only with overflow flagged and the write issued
  a_r7_trap_with_write: assert property (@(posedge clk) disable iff (rst)
    (trap_req && trap_vec == OVF_VEC) |-> (cc[2] && wr_hi && out_valid));

  // R8: odd pair traps and leaves state alone
  a_r8_odd_pair: assert property (@(posedge clk) disable iff (rst)
    (in_valid && op == OP_DBL && reg_idx[0]) |=>
      (trap_req && trap_vec == ODD_VEC && !wr_hi && !wr_lo && $stable(cc)
       && $stable(res_hi) && $stable(res_lo)));

  // R9: idle cycle changes nothing
  a_r9_idle_quiet: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> (!out_valid && !wr_hi && !wr_lo && !trap_req
                   && $stable(cc) && $stable(res_hi)));

  // R11: reserved opcode writes nothing
  a_r11_reserved: assert property (@(posedge clk) disable iff (rst)
    (in_valid && op == 2'b11) |=> (out_valid && !wr_hi && !wr_lo && !trap_req
                                   && $stable(cc)));

endmodule

// File: tb/fxsub_unit_tb.sv
module fxsub_unit_tb;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 20000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [1:0]  op = '0;
  logic [3:0]  reg_idx = '0;
  logic [31:0] reg_hi = '0, reg_lo = '0;
  logic [63:0] operand = '0;
  logic        trap_mask = 1'b0;
  logic        out_valid, wr_hi, wr_lo, trap_req;
  logic [31:0] res_hi, res_lo;
  logic [3:0]  cc;
  logic [7:0]  trap_vec;

  always #(CLK_PERIOD/2) clk = ~clk;

  fxsub_unit u_dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .op(op), .reg_idx(reg_idx),
    .reg_hi(reg_hi), .reg_lo(reg_lo), .operand(operand), .trap_mask(trap_mask),
    .out_valid(out_valid), .res_hi(res_hi), .res_lo(res_lo), .wr_hi(wr_hi),
    .wr_lo(wr_lo), .cc(cc), .trap_req(trap_req), .trap_vec(trap_vec)
  );

  typedef struct {
    logic [31:0] hi;
    logic [31:0] lo;
    logic        whi;
    logic        wlo;
    logic [3:0]  cc;
    logic        tr;
    logic [7:0]  tv;
    string       req;
  } exp_t;

  exp_t        sb[$];
  logic [31:0] rf[16];
  logic [31:0] m_hi = '0, m_lo = '0;
  logic [3:0]  m_cc = '0;
  int checks = 0;
  int errors = 0;

  task automatic check(input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic logic [1:0] cls_of(input logic [63:0] v, input int w);
    logic n;
    n = (w == 64) ? v[63] : v[31];
    if (n) return 2'b10;
    if ((w == 64 ? v : {32'b0, v[31:0]}) == 64'b0) return 2'b00;
    return 2'b01;
  endfunction

  task automatic issue(input logic [1:0] o, input logic [3:0] idx,
                       input logic [63:0] opnd, input logic msk, input string req);
    exp_t e;
    logic [31:0] a, b;
    logic [63:0] A, R;
    longint d;
    logic ov, cy;
    @(negedge clk);
    op = o; reg_idx = idx; operand = opnd; trap_mask = msk;
    reg_hi = rf[idx]; reg_lo = rf[4'(idx + 1)];
    in_valid = 1'b1;
    e.req = req; e.whi = 0; e.wlo = 0; e.tr = 0; e.tv = 0;
    if (o == 2'b10 && idx[0]) begin
      e.tr = 1; e.tv = 8'h4D;
    end else if (o == 2'b00 || o == 2'b01) begin
      a = rf[idx];
      b = (o == 2'b00) ? {{16{opnd[15]}}, opnd[15:0]} : opnd[31:0];
      d = longint'($signed(a)) - longint'($signed(b));
      ov = (d > 64'sd2147483647) || (d < -64'sd2147483648);
      cy = (a >= b);
      m_hi = d[31:0]; m_lo = '0;
      m_cc = {cy, ov, cls_of({32'b0, d[31:0]}, 32)};
      e.whi = 1;
      if (ov && msk) begin e.tr = 1; e.tv = 8'h43; end
      rf[idx] = m_hi;
    end else if (o == 2'b10) begin
      A = {rf[idx], rf[4'(idx + 1)]};
      R = A - opnd;
      cy = (A >= opnd);
      ov = (A[63] != opnd[63]) && (R[63] != A[63]);
      m_hi = R[63:32]; m_lo = R[31:0];
      m_cc = {cy, ov, cls_of(R, 64)};
      e.whi = 1; e.wlo = 1;
      if (ov && msk) begin e.tr = 1; e.tv = 8'h43; end
      rf[idx] = m_hi; rf[4'(idx + 1)] = m_lo;
    end
    e.hi = m_hi; e.lo = m_lo; e.cc = m_cc;
    sb.push_back(e);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid = 1'b0;
    end
  endtask

  // scoreboard monitor
  initial begin
    exp_t e;
    forever begin
      @(negedge clk);
      if (!rst && out_valid) begin
        if (sb.size() == 0) begin
          check("R9", "unexpected out_valid", 1, 0);
        end else begin
          e = sb.pop_front();
          check(e.req, "res_hi", {32'b0, res_hi}, {32'b0, e.hi});
          check(e.req, "res_lo", {32'b0, res_lo}, {32'b0, e.lo});
          check(e.req, "wr_hi/wr_lo", {62'b0, wr_hi, wr_lo}, {62'b0, e.whi, e.wlo});
          check({e.req, " R4 R5 R6"}, "cc", {60'b0, cc}, {60'b0, e.cc});
          check({e.req, " R7"}, "trap", {55'b0, trap_req, trap_vec}, {55'b0, e.tr, e.tv});
        end
      end
    end
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=%0d expected=0 pending", sb.size());
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < 16; i++) rf[i] = 32'(i * 32'h0101_0101);
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R10", "reset outputs", {res_hi, res_lo}, 64'b0);
    check("R10", "reset flags", {55'b0, out_valid, wr_hi, wr_lo, cc, trap_req},
          64'b0);
    rst = 1'b0;

    rf[2] = 32'd100;          issue(2'b00, 4'd2, 64'h0000_0000_0000_0007, 1, "R1");
    rf[3] = 32'd5;            issue(2'b00, 4'd3, 64'hABCD_0000_0000_FFFF, 1, "R1");
    rf[4] = 32'h7FFF_FFFF;    issue(2'b00, 4'd4, 64'h0000_0000_0000_FFFF, 1, "R1 R5 R7");
    rf[5] = 32'd0;            issue(2'b00, 4'd5, 64'h0000_0000_0000_8000, 0, "R1");
    idle(2);
    rf[6] = 32'h1234_5678;    issue(2'b01, 4'd6, 64'hFFFF_FFFF_1234_5678, 1, "R2 R6");
    rf[7] = 32'd0;            issue(2'b01, 4'd7, 64'h0000_0000_8000_0000, 1, "R2 R5 R7");
    rf[8] = 32'd0;            issue(2'b01, 4'd8, 64'h0000_0000_8000_0000, 0, "R2 R7");
    rf[9] = 32'd3;            issue(2'b01, 4'd9, 64'h0000_0000_0000_0004, 1, "R2 R4");
    idle(1);
    rf[10] = 32'h0000_0001; rf[11] = 32'h0000_0000;
    issue(2'b10, 4'd10, 64'h0000_0000_0000_0001, 1, "R3 R4");
    rf[12] = 32'h0; rf[13] = 32'h0;
    issue(2'b10, 4'd12, 64'h8000_0000_0000_0000, 1, "R3 R5 R7");
    rf[0] = 32'hDEAD_BEEF; rf[1] = 32'h0BAD_F00D;
    issue(2'b10, 4'd0, 64'hDEAD_BEEF_0BAD_F00D, 1, "R3 R6");
    issue(2'b10, 4'd3, 64'h1, 1, "R8");
    issue(2'b11, 4'd6, 64'h5, 1, "R11");
    issue(2'b01, 4'd6, 64'h1, 0, "R2");
    issue(2'b10, 4'd15, 64'h2, 0, "R8");
    idle(3);
    check("R9", "idle cc held", {60'b0, cc}, {60'b0, m_cc});
    check("R9", "idle no strobe", {61'b0, out_valid, wr_hi, trap_req}, 64'b0);

    for (int i = 0; i < 60; i++) begin
      issue(2'($urandom), 4'($urandom), {$urandom, $urandom}, 1'($urandom), "R1 R2 R3");
      if ((i % 7) == 3) idle(1);
    end
    idle(4);
    check("R9", "scoreboard drained", 64'(sb.size()), 64'b0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule